// File: doc/BRIEF.md
# Blit Job Queue and Completion Tracker

This block keeps the bookkeeping for two DMA copy channels: one moves data toward the device, the other toward system memory. A requester offers a job descriptor together with a direction bit. The block picks the channel from the direction. It stores the descriptor in that channel's slot ring and returns a sequence handle at once. Each channel runs one job at a time. When the channel is idle and work is waiting, the block launches the oldest queued descriptor. It then watches the channel's done and enable status lines to detect completion.

A per-channel cycle timer guards each running job. If a job runs past its budget, the block issues an abort. It then treats the job as finished as soon as the channel's enable status drops, with no done flag needed. Each completion raises a one-cycle event that tells whether the job was aborted. A cleanup agent then hands ring slots back one per cycle. A query port reports whether a given handle on a given channel is still pending. The test uses arithmetic that tolerates wrap of the 32-bit handle counters.

Top module: `blitq_top`

## Requirements
- R1: After reset each channel accepts at most SLOTS-1 submissions before any slot is released; one ring slot always stays unused.
- R2: Each channel numbers its accepted submissions 1, 2, 3, … on `sub_handle`, which is valid in the same cycle as `sub_gnt`.
- R3: `sub_to_dev`=1 routes a submission to channel 0 and `sub_to_dev`=0 routes it to channel 1; each channel has its own handle sequence.
- R4: A channel that is idle with queued work pulses `ch_start` one cycle after the clock edge that made the work visible. `ch_job` then carries the oldest queued descriptor, so descriptors start in submission order. A completion and the next launch share one clock edge.
- R5: While a job runs, a high `ch_done` at a clock edge completes it. In the following cycle `evt_done` and `ch_done_clr` pulse and `evt_aborted` is 0.
- R6: A job that neither completes nor is aborted gets an `ch_abort` pulse exactly TIMEOUT+1 cycles after its `ch_start` pulse. The timer then reloads.
- R7: Once aborting, the job completes at the first clock edge where `ch_en` is low, with `evt_done` and `evt_aborted` both high. While `ch_en` stays high and `ch_done` low, no completion occurs.
- R8: `ch_off` is high out of reset and in every cycle after an edge that left the channel with no running job and nothing queued. It is low while a job runs.
- R9: `q_pending` is 1 exactly when (done_count − q_handle) mod 2^32 > 2^WIN_LOG and (issued_count − q_handle) mod 2^32 ≤ 2^WIN_LOG, for the channel chosen by `q_ch` (0 or 1).
- R10: While a channel has no free slot, a request to it sees `sub_gnt` low and consumes no handle.
- R11: `cleanup_req` is high while completed jobs remain unreleased. Each edge with `rel_req` high and `cleanup_req` high releases one slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sub_req | input | 1 | Submission request |
| sub_to_dev | input | 1 | 1: toward device (channel 0), 0: toward memory (channel 1) |
| sub_job | input | JOB_W | Job descriptor to queue |
| sub_gnt | output | 1 | Submission accepted this cycle |
| sub_handle | output | 32 | Handle of the accepted submission |
| ch_start | output | 2 | Per-channel launch pulse |
| ch_job | output | 2*JOB_W | Launched descriptor, channel c at bits c*JOB_W upward |
| ch_abort | output | 2 | Per-channel abort pulse |
| ch_done_clr | output | 2 | Pulse clearing the channel's done status |
| ch_off | output | 2 | Channel switched off (idle, nothing queued) |
| ch_done | input | 2 | Channel done status |
| ch_en | input | 2 | Channel enable status |
| evt_done | output | 2 | Completion event pulse |
| evt_aborted | output | 2 | Completed job had been aborted |
| cleanup_req | output | 2 | Completed slots await release |
| rel_req | input | 2 | Cleanup agent releases one slot |
| q_ch | input | 1 | Channel of the handle query |
| q_handle | input | 32 | Handle to test |
| q_pending | output | 1 | Queried handle still pending |

## Verification
The hardest state to reach is a timed-out job that finishes through the abort path. That happens only after the timer has run out with the enable line still high, and it must be followed by a launch at the same edge. The stimulus holds `ch_done` low for the whole budget and then checks the abort cycle count. It drops `ch_en` for one cycle while two further jobs wait, so the aborted completion and the next launch coincide. A full ring with a release and a stalled request in flight is built the same directed way. A seeded random phase then mixes submissions, releases and done pulses against a model of free counts, handles and descriptor order.

// File: rtl/blitq_pkg.sv
package blitq_pkg;
    localparam int NUM_CH   = 2;
    localparam int HANDLE_W = 32;
    localparam int CH_TO_DEV = 0;
    localparam int CH_TO_MEM = 1;
    typedef logic [HANDLE_W-1:0] handle_t;
endpackage

// File: rtl/blitq_ring.sv
module blitq_ring
    import blitq_pkg::*;
#(
    parameter int SLOTS = 8,
    parameter int JOB_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [JOB_W-1:0] push_job,
    input  logic             complete,
    input  logic             launch,
    input  logic             release_req,
    output logic             can_push,
    output handle_t          next_handle,
    output handle_t          cur_handle,
    output handle_t          done_handle,
    output logic             work_left,
    output logic [JOB_W-1:0] launch_job,
    output logic             cleanup_req
);
    localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
    localparam int CNT_W = $clog2(SLOTS + 1);

    typedef struct packed {
        logic [IDX_W-1:0] head;
        logic [IDX_W-1:0] cur;
        logic [IDX_W-1:0] srv;
        logic [CNT_W-1:0] free;
        logic [CNT_W-1:0] outst;
        handle_t          cur_h;
        handle_t          done_h;
    } ring_t;

    function automatic logic [IDX_W-1:0] wrap_inc(input logic [IDX_W-1:0] i);
        return (i == IDX_W'(SLOTS - 1)) ? '0 : i + 1'b1;
    endfunction

    ring_t            r_q, r_d;
    logic [JOB_W-1:0] slot_q [SLOTS];
    logic             rel_ok;
    logic [IDX_W-1:0] cur_next;

    always_comb begin
        r_d    = r_q;
        rel_ok = release_req && (r_q.srv != r_q.cur);
        if (push) begin
            r_d.head  = wrap_inc(r_q.head);
            r_d.cur_h = r_q.cur_h + 1'b1;
        end
        if (complete) begin
            r_d.cur    = wrap_inc(r_q.cur);
            r_d.done_h = r_q.done_h + 1'b1;
        end
        if (rel_ok) begin
            r_d.srv = wrap_inc(r_q.srv);
        end
        r_d.free  = r_q.free - CNT_W'(push) + CNT_W'(rel_ok);
        r_d.outst = r_q.outst + CNT_W'(push) - CNT_W'(launch);
        cur_next  = complete ? wrap_inc(r_q.cur) : r_q.cur;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.head   <= '0;
            r_q.cur    <= '0;
            r_q.srv    <= '0;
            r_q.free   <= CNT_W'(SLOTS - 1);
            r_q.outst  <= '0;
            r_q.cur_h  <= '0;
            r_q.done_h <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_ff @(posedge clk) begin
        if (push) begin
            slot_q[r_q.head] <= push_job;
        end
    end

    assign can_push    = (r_q.free != '0);
    assign next_handle = r_q.cur_h + 1'b1;
    assign cur_handle  = r_q.cur_h;
    assign done_handle = r_q.done_h;
    assign work_left   = (r_q.outst != '0);
    assign launch_job  = slot_q[cur_next];
    assign cleanup_req = (r_q.srv != r_q.cur);

    p_free_cap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.free <= CNT_W'(SLOTS - 1));
    p_no_push_when_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (r_q.free != '0));
    p_handle_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> (r_q.cur_h == $past(r_q.cur_h) + 1'b1));
    p_release_frees_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (release_req && cleanup_req && !push) |=> (r_q.free == $past(r_q.free) + 1'b1));
    p_launch_has_work_r4: assert property (@(posedge clk) disable iff (!rst_n)
        launch |-> (r_q.outst != '0));
endmodule

// File: rtl/blitq_seq.sv
module blitq_seq #(
    parameter int JOB_W   = 16,
    parameter int TIMEOUT = 1024
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             done_st,
    input  logic             en_st,
    input  logic             work_left,
    input  logic [JOB_W-1:0] launch_job,
    output logic             complete,
    output logic             launch,
    output logic             ch_start,
    output logic [JOB_W-1:0] ch_job,
    output logic             ch_abort,
    output logic             ch_done_clr,
    output logic             ch_off,
    output logic             evt_done,
    output logic             evt_aborted
);
    localparam int TMR_W = $clog2(TIMEOUT + 1);

    typedef struct packed {
        logic             active;
        logic             aborting;
        logic             start;
        logic             abort;
        logic             clr;
        logic             off;
        logic             evt;
        logic             evt_ab;
        logic [TMR_W-1:0] timer;
        logic [JOB_W-1:0] job;
    } seq_t;

    seq_t s_q, s_d;

    always_comb begin
        s_d        = s_q;
        s_d.start  = 1'b0;
        s_d.abort  = 1'b0;
        s_d.clr    = 1'b0;
        s_d.evt    = 1'b0;
        s_d.evt_ab = 1'b0;
        complete   = (s_q.active && done_st) || (s_q.aborting && !en_st);
        if (complete) begin
            s_d.evt      = 1'b1;
            s_d.evt_ab   = s_q.aborting;
            s_d.clr      = 1'b1;
            s_d.active   = 1'b0;
            s_d.aborting = 1'b0;
        end else if (s_q.active) begin
            if (s_q.timer == '0) begin
                s_d.abort    = 1'b1;
                s_d.aborting = 1'b1;
                s_d.timer    = TMR_W'(TIMEOUT);
            end else begin
                s_d.timer = s_q.timer - 1'b1;
            end
        end
        launch = !s_d.active && work_left;
        if (launch) begin
            s_d.start  = 1'b1;
            s_d.job    = launch_job;
            s_d.active = 1'b1;
            s_d.timer  = TMR_W'(TIMEOUT);
        end
        s_d.off = !s_d.active;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q     <= '0;
            s_q.off <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign ch_start    = s_q.start;
    assign ch_job      = s_q.job;
    assign ch_abort    = s_q.abort;
    assign ch_done_clr = s_q.clr;
    assign ch_off      = s_q.off;
    assign evt_done    = s_q.evt;
    assign evt_aborted = s_q.evt_ab;

    p_abort_needs_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.active && !complete && (s_q.timer != '0) |=> !ch_abort);
    p_complete_idles_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (complete && !launch) |=> !s_q.active);
    p_start_when_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        launch |-> (!s_q.active || complete));
    p_abort_finish_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.aborting && !en_st && !done_st) |=> (evt_done && evt_aborted));
    p_no_abort_flag_when_clean_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.active && !s_q.aborting && done_st) |=> (evt_done && !evt_aborted));
endmodule

// File: rtl/blitq_pending.sv
module blitq_pending
    import blitq_pkg::*;
#(
    parameter int WIN_LOG = 23
) (
    input  handle_t done_h,
    input  handle_t cur_h,
    input  handle_t q_h,
    output logic    pending
);
    localparam handle_t WIN = handle_t'(1) << WIN_LOG;

    handle_t since_done;
    handle_t since_issue;

    always_comb begin
        since_done  = done_h - q_h;
        since_issue = cur_h - q_h;
        pending     = (since_done > WIN) && (since_issue <= WIN);
    end
endmodule

// File: rtl/blitq_top.sv
module blitq_top
    import blitq_pkg::*;
#(
    parameter int SLOTS   = 8,
    parameter int JOB_W   = 16,
    parameter int TIMEOUT = 1024,
    parameter int WIN_LOG = 23
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sub_req,
    input  logic                    sub_to_dev,
    input  logic [JOB_W-1:0]        sub_job,
    output logic                    sub_gnt,
    output logic [31:0]             sub_handle,
    output logic [1:0]              ch_start,
    output logic [2*JOB_W-1:0]      ch_job,
    output logic [1:0]              ch_abort,
    output logic [1:0]              ch_done_clr,
    output logic [1:0]              ch_off,
    input  logic [1:0]              ch_done,
    input  logic [1:0]              ch_en,
    output logic [1:0]              evt_done,
    output logic [1:0]              evt_aborted,
    output logic [1:0]              cleanup_req,
    input  logic [1:0]              rel_req,
    input  logic                    q_ch,
    input  logic [31:0]             q_handle,
    output logic                    q_pending
);
    logic [NUM_CH-1:0] can_push, push, complete, launch, work_left;
    handle_t           nxt_h  [NUM_CH];
    handle_t           cur_h  [NUM_CH];
    handle_t           done_h [NUM_CH];
    logic [JOB_W-1:0]  l_job  [NUM_CH];
    logic              sel;

    assign sel = sub_to_dev ? 1'(CH_TO_DEV) : 1'(CH_TO_MEM);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign push[c] = sub_req && (sel == 1'(c)) && can_push[c];

        blitq_ring #(.SLOTS(SLOTS), .JOB_W(JOB_W)) u_ring (
            .clk         (clk),
            .rst_n       (rst_n),
            .push        (push[c]),
            .push_job    (sub_job),
            .complete    (complete[c]),
            .launch      (launch[c]),
            .release_req (rel_req[c]),
            .can_push    (can_push[c]),
            .next_handle (nxt_h[c]),
            .cur_handle  (cur_h[c]),
            .done_handle (done_h[c]),
            .work_left   (work_left[c]),
            .launch_job  (l_job[c]),
            .cleanup_req (cleanup_req[c])
        );

        blitq_seq #(.JOB_W(JOB_W), .TIMEOUT(TIMEOUT)) u_seq (
            .clk         (clk),
            .rst_n       (rst_n),
            .done_st     (ch_done[c]),
            .en_st       (ch_en[c]),
            .work_left   (work_left[c]),
            .launch_job  (l_job[c]),
            .complete    (complete[c]),
            .launch      (launch[c]),
            .ch_start    (ch_start[c]),
            .ch_job      (ch_job[c*JOB_W +: JOB_W]),
            .ch_abort    (ch_abort[c]),
            .ch_done_clr (ch_done_clr[c]),
            .ch_off      (ch_off[c]),
            .evt_done    (evt_done[c]),
            .evt_aborted (evt_aborted[c])
        );
    end

    assign sub_gnt    = sub_req && can_push[sel];
    assign sub_handle = nxt_h[sel];

    blitq_pending #(.WIN_LOG(WIN_LOG)) u_pend (
        .done_h  (done_h[q_ch]),
        .cur_h   (cur_h[q_ch]),
        .q_h     (q_handle),
        .pending (q_pending)
    );

    p_done_not_pending_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (q_handle == done_h[q_ch]) |-> !q_pending);
    p_route_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sub_gnt |-> (push[0] == sub_to_dev) && (push[1] == !sub_to_dev));
endmodule

// File: tb/tb_blitq_top.sv
module tb_blitq_top;
    localparam int SLOTS = 4;
    localparam int JW    = 8;
    localparam int TMO   = 200;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sub_req = 1'b0, sub_to_dev = 1'b0;
    logic [JW-1:0] sub_job = '0;
    logic          sub_gnt;
    logic [31:0]   sub_handle;
    logic [1:0]    ch_start, ch_abort, ch_done_clr, ch_off, evt_done, evt_aborted, cleanup_req;
    logic [2*JW-1:0] ch_job;
    logic [1:0]    ch_done = 2'b00, ch_en = 2'b11, rel_req = 2'b00;
    logic          q_ch = 1'b0;
    logic [31:0]   q_handle = '0;
    logic          q_pending;

    int n_cmp = 0, n_bad = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    blitq_top #(.SLOTS(SLOTS), .JOB_W(JW), .TIMEOUT(TMO), .WIN_LOG(23)) dut (
        .clk(clk), .rst_n(rst_n), .sub_req(sub_req), .sub_to_dev(sub_to_dev),
        .sub_job(sub_job), .sub_gnt(sub_gnt), .sub_handle(sub_handle),
        .ch_start(ch_start), .ch_job(ch_job), .ch_abort(ch_abort),
        .ch_done_clr(ch_done_clr), .ch_off(ch_off), .ch_done(ch_done), .ch_en(ch_en),
        .evt_done(evt_done), .evt_aborted(evt_aborted), .cleanup_req(cleanup_req),
        .rel_req(rel_req), .q_ch(q_ch), .q_handle(q_handle), .q_pending(q_pending)
    );

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_submit(input logic to_dev, input logic [JW-1:0] job,
                             output logic g, output logic [31:0] h);
        sub_req = 1'b1; sub_to_dev = to_dev; sub_job = job;
        #1;
        g = sub_gnt; h = sub_handle;
        tick();
        sub_req = 1'b0;
    endtask

    function automatic logic ref_pending(input logic [31:0] dn, input logic [31:0] cu,
                                         input logic [31:0] h);
        logic [31:0] w;
        w = 32'h1 << 23;
        return ((dn - h) > w) && ((cu - h) <= w);
    endfunction

    task automatic query(input logic ch, input logic [31:0] h, input logic [31:0] dn,
                         input logic [31:0] cu);
        q_ch = ch; q_handle = h;
        #1;
        chk("R9 pending query", q_pending, ref_pending(dn, cu, h));
    endtask

    // random-phase model
    int           free_m [2];
    int           exp_h  [2];
    int           comp   [2];
    int           serv   [2];
    int           wr     [2];
    int           rd     [2];
    logic         act    [2];
    logic [JW-1:0] fq    [2][64];

    task automatic observe();
        for (int c = 0; c < 2; c++) begin
            if (evt_done[c]) begin act[c] = 1'b0; comp[c]++; end
            if (ch_start[c]) begin
                chk("R4 launch order", ch_job[c*JW +: JW], fq[c][rd[c] % 64]);
                rd[c]++;
                act[c] = 1'b1;
            end
        end
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic g;
        logic [31:0] h;
        int t_start;
        int guard;
        int r;

        r = $urandom(32'h5EED_0042);
        repeat (3) tick();
        chk("R8 off in reset", ch_off, 2'b11);
        chk("R5 no event in reset", evt_done, 2'b00);
        chk("R11 no cleanup in reset", cleanup_req, 2'b00);
        rst_n = 1'b1;
        tick();

        // first job toward device -> channel 0
        do_submit(1'b1, 8'hA1, g, h);
        chk("R2 first grant", g, 1);
        chk("R2 first handle", h, 1);
        tick();
        chk("R4 start ch0 only", ch_start, 2'b01);
        chk("R4 job A", ch_job[7:0], 8'hA1);
        chk("R8 ch0 running", ch_off[0], 0);

        // job toward memory -> channel 1, own handle sequence
        do_submit(1'b0, 8'hE1, g, h);
        chk("R3 ch1 grant", g, 1);
        chk("R3 ch1 handle", h, 1);
        tick();
        chk("R3 start ch1 only", ch_start, 2'b10);
        chk("R3 ch1 job", ch_job[15:8], 8'hE1);
        ch_done[1] = 1'b1;
        tick();
        ch_done[1] = 1'b0;
        chk("R5 ch1 event", evt_done, 2'b10);
        chk("R5 ch1 not aborted", evt_aborted[1], 0);
        chk("R5 ch1 done clear", ch_done_clr[1], 1);
        chk("R8 ch1 off after drain", ch_off[1], 1);

        // fill channel 0
        do_submit(1'b1, 8'hB2, g, h);
        chk("R2 handle 2", h, 2);
        do_submit(1'b1, 8'hC3, g, h);
        chk("R2 handle 3", h, 3);
        do_submit(1'b1, 8'hFF, g, h);
        chk("R1 ring keeps one slot empty", g, 0);

        // queries: ch0 issued 3, done 0; ch1 issued 1, done 1
        query(1'b0, 32'd1, 32'd0, 32'd3);
        query(1'b0, 32'd3, 32'd0, 32'd3);
        query(1'b0, 32'd4, 32'd0, 32'd3);
        query(1'b0, 32'd0, 32'd0, 32'd3);
        query(1'b0, 32'h8000_0000, 32'd0, 32'd3);
        query(1'b0, 32'hFF80_0003, 32'd0, 32'd3);
        query(1'b1, 32'd1, 32'd1, 32'd1);

        // complete A via done: B launches at the same edge
        ch_done[0] = 1'b1;
        tick();
        ch_done[0] = 1'b0;
        t_start = cyc;
        chk("R5 ch0 event", evt_done[0], 1);
        chk("R5 ch0 clean", evt_aborted[0], 0);
        chk("R5 ch0 done clear", ch_done_clr[0], 1);
        chk("R4 back-to-back start", ch_start[0], 1);
        chk("R4 job B follows A", ch_job[7:0], 8'hB2);
        query(1'b0, 32'd1, 32'd1, 32'd3);

        // release path
        chk("R11 cleanup pending", cleanup_req[0], 1);
        do_submit(1'b1, 8'hEE, g, h);
        chk("R10 stall while full", g, 0);
        rel_req[0] = 1'b1;
        tick();
        rel_req[0] = 1'b0;
        chk("R11 cleanup serviced", cleanup_req[0], 0);
        do_submit(1'b1, 8'hD4, g, h);
        chk("R10 grant after release", g, 1);
        chk("R10 stalled request used no handle", h, 4);

        // timeout on B
        guard = 0;
        while (!ch_abort[0] && guard < 1000) begin tick(); guard++; end
        chk("R6 abort cycle", cyc - t_start, TMO + 1);
        chk("R6 no completion at abort", evt_done[0], 0);
        guard = 0;
        for (int k = 0; k < 3; k++) begin
            tick();
            if (evt_done[0]) guard++;
        end
        chk("R7 no completion while enabled", guard, 0);
        ch_en[0] = 1'b0;
        tick();
        ch_en[0] = 1'b1;
        chk("R7 aborted completion", evt_done[0], 1);
        chk("R7 aborted flag", evt_aborted[0], 1);
        chk("R4 job C after abort", ch_job[7:0], 8'hC3);

        ch_done[0] = 1'b1; tick(); ch_done[0] = 1'b0;
        chk("R4 job D", ch_job[7:0], 8'hD4);
        chk("R8 ch0 busy", ch_off[0], 0);
        ch_done[0] = 1'b1; tick(); ch_done[0] = 1'b0;
        chk("R8 ch0 off after last job", ch_off[0], 1);

        rel_req = 2'b11;
        guard = 0;
        while (cleanup_req != 2'b00 && guard < 20) begin tick(); guard++; end
        rel_req = 2'b00;
        chk("R11 drained", cleanup_req, 2'b00);

        // seeded random phase
        free_m = '{SLOTS-1, SLOTS-1};
        exp_h  = '{4, 1};
        comp = '{0, 0}; serv = '{0, 0}; wr = '{0, 0}; rd = '{0, 0};
        act = '{1'b0, 1'b0};
        for (int i = 0; i < 600; i++) begin
            int   ch;
            logic rl [2];
            observe();
            for (int c = 0; c < 2; c++) begin
                rl[c] = (comp[c] > serv[c]) && ($urandom % 2 == 0);
                rel_req[c] = rl[c];
                ch_done[c] = act[c] && ($urandom % 3 == 0);
            end
            sub_req = ($urandom % 2 == 0);
            sub_to_dev = $urandom % 2;
            sub_job = JW'($urandom);
            ch = sub_to_dev ? 0 : 1;
            #1;
            if (sub_req) begin
                chk("R10 grant vs free", sub_gnt, free_m[ch] != 0);
                if (free_m[ch] != 0) begin
                    exp_h[ch]++;
                    chk("R2 random handle", sub_handle, exp_h[ch]);
                    fq[ch][wr[ch] % 64] = sub_job;
                    wr[ch]++;
                    free_m[ch]--;
                end
            end
            for (int c = 0; c < 2; c++) begin
                if (rl[c]) begin serv[c]++; free_m[c]++; end
            end
            tick();
        end
        sub_req = 1'b0;
        for (int i = 0; i < 80; i++) begin
            observe();
            for (int c = 0; c < 2; c++) begin
                ch_done[c] = act[c];
                rel_req[c] = (comp[c] > serv[c]);
                if (rel_req[c]) serv[c]++;
            end
            tick();
        end
        ch_done = 2'b00; rel_req = 2'b00;
        tick();
        chk("R8 both off at end", ch_off, 2'b11);
        chk("R11 nothing left to release", cleanup_req, 2'b00);
        chk("R4 every queued job launched", rd[0] + rd[1], wr[0] + wr[1]);
        for (int k = 0; k < SLOTS; k++) begin
            do_submit(1'b0, 8'h10, g, h);
            chk("R1 capacity after drain", g, (k < SLOTS - 1) ? 1 : 0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule